// File: doc/BRIEF.md
# Four-Channel LED Dimming PWM with Shared Intensity

This block drives four constant-current LED sink outputs from one free-running step counter with a 256-step period. Each channel compares the counter against a ratio code that sets how many steps of each period it sinks current. A channel takes that code either from its own register or from one shared register. The shared register lets software dim a group of LEDs with a single write.

A small write port loads the four channel codes, the shared code and a select mask. The outputs never change intensity partway through a period. Each channel keeps a shadow copy of the code it is using. The shadow loads from the selected source only when the counter wraps. A channel can therefore move between its own code and the shared one without a runt or stretched pulse. A global enable stops the counter at step 0 and turns every output off. When enable returns, a fresh period starts at step 0.

Top module: `led_pwm_array`

## Requirements
- R1: After reset every ratio code is 0, every select bit picks the channel's own code, and all `sink_on` outputs are 0. They stay 0 while enabled until a nonzero code is written.
- R2: A code N from 0 to 254 makes the channel sink for exactly N steps of each 256-step period, on the steps whose counter value is below N.
- R3: Code 255 makes the channel sink on all 256 steps of the period.
- R4: Write addresses 0 to 3 load the own code of channel 0 to 3, and address 4 loads the shared code. Address 5 loads the select mask: bit i set makes channel i use the shared code, and bit i clear makes it use its own code.
- R5: The shared code is decoded exactly like an own code. One write to it changes every channel whose select bit is set.
- R6: A change to a code or to a select bit made during a period leaves the rest of that period unchanged. It takes effect from step 0 of the next period.
- R7: While `en` is low, every `sink_on` bit is 0 and the counter is held at step 0. After `en` rises, the counter counts up from step 0 using the settings current at that time.
- R8: Writes to addresses 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one PWM step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low holds the counter at step 0 and outputs off |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address (0-3 own codes, 4 shared code, 5 select mask) |
| wr_data | input | 8 | Write data |
| sink_on | output | 4 | Per-channel sink enable |

## Verification
The hardest case to reach is a write that lands in the middle of a period. Checking it means knowing where the counter stands, which the ports do not reveal. The bench keeps its own step-by-step model of the counter and the shadow copies. It uses that model to time writes to chosen steps, for example step 100 of a period. It then checks the affected channel at a later step of the same period, where the old code still applies. It checks the same step again one period later, where the new code applies. The same timing is used for a select bit that flips mid-period. A random phase then mixes writes to every address with enable drops at arbitrary steps, and the model is compared on every cycle.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

   // Source of the effective code for one channel.
   typedef enum logic {
      SRC_OWN    = 1'b0,
      SRC_SHARED = 1'b1
   } led_src_e;

   // Address width for the channel codes plus the shared code and the select mask.
   function automatic int reg_addr_width(input int num_ch);
      return $clog2(num_ch + 2);
   endfunction

endpackage

// File: rtl/led_pwm_counter.sv
module led_pwm_counter #(
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   output logic [STEP_W-1:0] step,
   output logic              wrap
);
   localparam logic [STEP_W-1:0] LAST_STEP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (!en) begin
         step <= '0;
      end else begin
         step <= step + 1'b1;
      end
   end

   assign wrap = (step == LAST_STEP);
endmodule

// File: rtl/led_pwm_regs.sv
module led_pwm_regs #(
   parameter int NUM_CH  = 4,
   parameter int RATIO_W = 8,
   parameter int ADDR_W  = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [RATIO_W-1:0]              wr_data,
   output logic [NUM_CH-1:0][RATIO_W-1:0]  own_code,
   output logic [RATIO_W-1:0]              shared_code,
   output logic [NUM_CH-1:0]               use_shared
);
   localparam logic [ADDR_W-1:0] SHARED_ADDR = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] SELECT_ADDR = ADDR_W'(NUM_CH + 1);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_own
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            own_code[g] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
            own_code[g] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shared_code <= '0;
         use_shared  <= '0;
      end else if (wr_en) begin
         if (wr_addr == SHARED_ADDR) begin
            shared_code <= wr_data;
         end
         if (wr_addr == SELECT_ADDR) begin
            use_shared <= wr_data[NUM_CH-1:0];
         end
      end
   end
endmodule

// File: rtl/led_pwm_channel.sv
module led_pwm_channel #(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               load,
   input  logic [RATIO_W-1:0] own_code,
   input  logic [RATIO_W-1:0] shared_code,
   input  led_pwm_pkg::led_src_e src,
   input  logic [RATIO_W-1:0] step,
   output logic [RATIO_W-1:0] shadow,
   output logic               sink
);
   localparam logic [RATIO_W-1:0] FULL_ON = '1;

   logic [RATIO_W-1:0] next_code;

   always_comb begin
      next_code = (src == led_pwm_pkg::SRC_SHARED) ? shared_code : own_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (load) begin
         shadow <= next_code;
      end
   end

   assign sink = en && ((shadow == FULL_ON) || (step < shadow));
endmodule

// File: rtl/led_pwm_array.sv
module led_pwm_array #(
   parameter int NUM_CH  = 4,
   parameter int RATIO_W = 8,
   parameter int ADDR_W  = led_pwm_pkg::reg_addr_width(NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [RATIO_W-1:0] wr_data,
   output logic [NUM_CH-1:0]  sink_on
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("led_pwm_array: NUM_CH must be at least 1");
   end
   if (NUM_CH > RATIO_W) begin : g_bad_mask
      $error("led_pwm_array: select mask must fit in one data word");
   end
   if (RATIO_W < 2) begin : g_bad_w
      $error("led_pwm_array: RATIO_W must be at least 2");
   end
   if (ADDR_W < led_pwm_pkg::reg_addr_width(NUM_CH)) begin : g_bad_aw
      $error("led_pwm_array: ADDR_W too narrow for the register map");
   end

   logic [RATIO_W-1:0]              cnt_q;
   logic                            wrap_w;
   logic [NUM_CH-1:0][RATIO_W-1:0]  own_w;
   logic [RATIO_W-1:0]              shared_w;
   logic [NUM_CH-1:0]               sel_w;
   logic [NUM_CH-1:0][RATIO_W-1:0]  shadow_w;
   logic                            load_w;

   led_pwm_counter #(.STEP_W(RATIO_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .step  (cnt_q),
      .wrap  (wrap_w)
   );

   led_pwm_regs #(.NUM_CH(NUM_CH), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .own_code    (own_w),
      .shared_code (shared_w),
      .use_shared  (sel_w)
   );

   // Shadows follow their source while idle and latch only at the period wrap.
   assign load_w = !en || wrap_w;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      led_pwm_channel #(.RATIO_W(RATIO_W)) ch_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .en          (en),
         .load        (load_w),
         .own_code    (own_w[g]),
         .shared_code (shared_w),
         .src         (led_pwm_pkg::led_src_e'(sel_w[g])),
         .step        (cnt_q),
         .shadow      (shadow_w[g]),
         .sink        (sink_on[g])
      );
   end
endmodule

// File: rtl/led_pwm_array_chk.sv
module led_pwm_array_chk #(
   parameter int NUM_CH  = 4,
   parameter int RATIO_W = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            en,
   input logic [RATIO_W-1:0]              cnt,
   input logic [NUM_CH-1:0][RATIO_W-1:0]  shadow,
   input logic [NUM_CH-1:0]               sink
);
   localparam logic [RATIO_W-1:0] MAX_STEP = '1;

   assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (sink == '0));

   assert_counter_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   assert_counter_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt == RATIO_W'($past(cnt) + 1'b1)));

   assert_shadow_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (cnt != MAX_STEP)) |=> $stable(shadow));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      assert_full_code_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (en && (shadow[g] == MAX_STEP)) |-> sink[g]);

      assert_zero_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (shadow[g] == '0) |-> !sink[g]);
   end
endmodule

bind led_pwm_array led_pwm_array_chk #(.NUM_CH(NUM_CH), .RATIO_W(RATIO_W)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .cnt    (cnt_q),
   .shadow (shadow_w),
   .sink   (sink_on)
);

// File: tb/led_pwm_array_tb_top.sv
module led_pwm_array_tb_top;
   localparam int NCH = 4;
   localparam int W   = 8;
   localparam int AW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [NCH-1:0] sink;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   led_pwm_array dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sink_on (sink)
   );

   // Reference model built from the requirements.
   logic [W-1:0]   m_own [NCH];
   logic [W-1:0]   m_com;
   logic [NCH-1:0] m_sel;
   logic [W-1:0]   m_sh [NCH];
   logic [W-1:0]   m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_own[i] <= '0;
            m_sh[i]  <= '0;
         end
         m_com <= '0;
         m_sel <= '0;
         m_cnt <= '0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (!en || m_cnt == 8'hFF) m_sh[i] <= m_sel[i] ? m_com : m_own[i];
            if (wr_en && wr_addr == AW'(i)) m_own[i] <= wr_data;
         end
         if (wr_en && wr_addr == 3'd4) m_com <= wr_data;
         if (wr_en && wr_addr == 3'd5) m_sel <= wr_data[NCH-1:0];
         m_cnt <= en ? m_cnt + 8'd1 : 8'd0;
      end
   end

   function automatic bit exp_on(input logic [W-1:0] sh, input logic [W-1:0] c, input logic e);
      return e && (sh == 8'hFF || c < sh);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Advance one cycle and compare every channel with the model.
   task automatic tick();
      @(negedge clk);
      if (rst_n) begin
         for (int i = 0; i < NCH; i++)
            chk("R2/R3/R4/R5/R6/R7 per-cycle model", int'(sink[i]),
                int'(exp_on(m_sh[i], m_cnt, en)));
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = W'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (260) tick();
   endtask

   task automatic count_period(output int cnt [NCH]);
      for (int i = 0; i < NCH; i++) cnt[i] = 0;
      repeat (256) begin
         tick();
         for (int i = 0; i < NCH; i++) cnt[i] += int'(sink[i]);
      end
   endtask

   function automatic logic [W-1:0] rnd_code();
      int p = int'($urandom_range(0, 7));
      if (p == 0) return 8'h00;
      if (p == 1) return 8'hFE;
      if (p == 2) return 8'hFF;
      return W'($urandom_range(0, 255));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n [NCH];
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R1 outputs off in reset", int'(sink), 0);
      rst_n = 1'b1;
      en = 1'b1;
      count_period(n);
      for (int i = 0; i < NCH; i++) chk("R1 reset code gives no light", n[i], 0);

      // R2: several own codes
      wr(0, 0); wr(1, 1); wr(2, 128); wr(3, 254);
      settle();
      count_period(n);
      chk("R2 code 0", n[0], 0);
      chk("R2 code 1", n[1], 1);
      chk("R2 code 128", n[2], 128);
      chk("R2 code 254", n[3], 254);

      // R3: full code
      wr(0, 255);
      settle();
      count_period(n);
      chk("R3 code 255 always on", n[0], 256);

      // R4/R5: shared code and select mask
      wr(4, 100);
      wr(5, 5);
      settle();
      count_period(n);
      chk("R4 ch0 takes shared", n[0], 100);
      chk("R4 ch1 keeps own", n[1], 1);
      chk("R4 ch2 takes shared", n[2], 100);
      chk("R4 ch3 keeps own", n[3], 254);
      wr(4, 30);
      settle();
      count_period(n);
      chk("R5 shared write ch0", n[0], 30);
      chk("R5 shared write ch2", n[2], 30);
      chk("R5 own channel unaffected", n[3], 254);

      // R6: own code change mid-period
      wr(5, 0);
      wr(1, 10);
      settle();
      while (m_cnt != 8'd100) tick();
      wr(1, 200);
      while (m_cnt != 8'd150) tick();
      chk("R6 old code kept in current period", int'(sink[1]), 0);
      tick();
      while (m_cnt != 8'd150) tick();
      chk("R6 new code from next period", int'(sink[1]), 1);

      // R6: select change mid-period
      wr(4, 220);
      wr(2, 20);
      settle();
      while (m_cnt != 8'd50) tick();
      wr(5, 4);
      while (m_cnt != 8'd100) tick();
      chk("R6 select held in current period", int'(sink[2]), 0);
      tick();
      while (m_cnt != 8'd100) tick();
      chk("R6 select applied next period", int'(sink[2]), 1);

      // R7: enable low mid-period, restart at step 0
      wr(5, 0);
      wr(0, 5);
      settle();
      while (m_cnt != 8'd77) tick();
      en = 1'b0;
      repeat (5) begin
         tick();
         chk("R7 outputs off while disabled", int'(sink), 0);
      end
      en = 1'b1;
      begin
         int on0 = 0;
         for (int k = 1; k <= 10; k++) begin
            tick();
            on0 += int'(sink[0]);
         end
         chk("R7 restart from step 0", on0, 4);
      end

      // R8: undefined addresses
      wr(0, 40); wr(1, 80); wr(2, 120); wr(3, 160);
      settle();
      wr(6, 255);
      wr(7, 255);
      settle();
      count_period(n);
      chk("R8 addr 6/7 ch0", n[0], 40);
      chk("R8 addr 6/7 ch1", n[1], 80);
      chk("R8 addr 6/7 ch2", n[2], 120);
      chk("R8 addr 6/7 ch3", n[3], 160);

      // Random phase checked against the model every cycle
      for (int t = 0; t < 6000; t++) begin
         if ($urandom_range(0, 299) == 0) en = ~en;
         else if (!en && $urandom_range(0, 9) == 0) en = 1'b1;
         if ($urandom_range(0, 15) == 0) begin
            int a = int'($urandom_range(0, 7));
            wr(a, (a == 5) ? int'($urandom_range(0, 15)) : int'(rnd_code()));
         end else begin
            tick();
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule